// File: doc/BRIEF.md
# Multiplierless Pipelined High-Pass FIR Filter

This block filters a stream of signed 24-bit audio samples with a fixed, linear-phase, high-pass FIR response. One sample can be offered per clock with a valid strobe. Each accepted sample produces exactly one filtered sample a fixed number of cycles later. Cycles without a valid sample are bubbles: they do not move the filter's history and do not produce an output.

The coefficients are integer constants fixed at elaboration. The datapath has no multiply operator and no add operator. Samples that meet a mirrored coefficient are first summed in pairs. Each pair sum is then scaled by its coefficient, written in canonical signed-digit form as a few shifted additions and subtractions. The partial products meet in a registered, balanced binary tree of hand-built ripple-carry adders. The result is arithmetically shifted down by the coefficient fraction width and clamped to the 24-bit range.

The default response has seven taps, h = {-8, -20, -36, 128, -36, -20, -8} with 7 fraction bits. The tap sum is zero, so constant input is removed completely.

Top module: `fir_hp_top`

## Requirements
- R1: For every valid output, out_sample (two's complement) equals floor((sum over k=0..6 of h[k]·x[n-k]) / 128), with h = {-8,-20,-36,128,-36,-20,-8} and x[n] the newest accepted sample, whenever that value lies in [-8388608, 8388607].
- R2: out_valid is in_valid delayed by exactly 5 clock cycles. Results leave in the order their samples arrived, and none is dropped or repeated.
- R3: A cycle with in_valid low neither shifts the sample history nor lets in_sample enter it, whatever in_sample carries.
- R4: When the scaled sum exceeds 8388607 the output is 8388607 (0x7FFFFF). When it is below -8388608 the output is -8388608 (0x800000).
- R5: A constant input held for at least 7 accepted samples yields an output of 0.
- R6: While rst_n is low, out_valid and out_sample are 0. The history and every pipeline stage are cleared, so samples in flight are discarded and results after reset treat all earlier history as 0.
- R7: A single nonzero sample followed by zeros yields outputs equal to that sample scaled by h[0] through h[6] in turn, divided by 128.
- R8: While out_valid is low, out_sample holds the last valid result, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | in_sample carries a new sample this cycle |
| in_sample | input | 24 | Input sample, two's complement |
| out_valid | output | 1 | out_sample carries a new result this cycle |
| out_sample | output | 24 | Filtered sample, two's complement, saturated |

## Verification
In one clock cycle the delay line can accept a fresh sample while the output register delivers the result of a sample taken five cycles earlier. Reset can also land while up to five samples are still in the pipeline. Back-to-back bursts, random bubbles of one to three cycles, and a reset issued right after three accepted samples all provoke these overlaps. A per-cycle behavioural model is the judge: it predicts out_valid from the valid history and each result from its own convolution, and it flags any output that is mistimed, reordered, left over from before a reset, or numerically wrong. During bubbles the model also confirms that out_sample holds its last value.

// File: rtl/fir_hp_pkg.sv
package fir_hp_pkg;

  localparam int DW     = 24;  // sample width
  localparam int NTAP   = 7;   // odd tap count, symmetric response
  localparam int FRAC   = 7;   // coefficient fraction bits
  localparam int CDIG   = 10;  // signed-digit positions per coefficient

  localparam int HALF   = NTAP / 2;
  localparam int NPROD  = HALF + 1;  // folded pairs plus the centre tap

  // Outer taps first, centre tap last.
  localparam int COEF [NPROD] = '{-8, -20, -36, 128};

  function automatic int coef_abs_sum();
    int s;
    s = 0;
    for (int k = 0; k < NPROD; k++) begin
      int a;
      a = (COEF[k] < 0) ? -COEF[k] : COEF[k];
      s = (k < HALF) ? (s + a + a) : (s + a);
    end
    return s;
  endfunction

  localparam int GUARD  = $clog2(coef_abs_sum());
  localparam int AW     = DW + 1 + GUARD;
  localparam int LEAVES = 1 << $clog2(NPROD);
  localparam int LVL    = $clog2(LEAVES);
  localparam int LAT    = LVL + 3;

  // Canonical signed-digit recoding: digit (-1, 0, +1) at position pos.
  function automatic int csd_digit(int c, int pos);
    int x;
    int d;
    x = c;
    d = 0;
    for (int i = 0; i <= pos; i++) begin
      if ((x & 1) != 0) d = ((x & 3) == 1) ? 1 : -1;
      else              d = 0;
      x = (x - d) >>> 1;
    end
    return d;
  endfunction

  typedef logic signed [DW-1:0] sample_t;
  typedef logic signed [AW-1:0] acc_t;

endpackage

// File: rtl/fir_hp_rca.sv
module fir_hp_rca #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] s
);

  logic [W-1:0] bx;
  logic [W-1:0] cy;

  assign bx    = b ^ {W{sub}};
  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = a[i] ^ bx[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
    end
  end

endmodule

// File: rtl/fir_hp_csd_mult.sv
module fir_hp_csd_mult
  import fir_hp_pkg::*;
#(
  parameter int IW   = DW + 1,
  parameter int OW   = AW,
  parameter int CF   = 1,
  parameter int NDIG = CDIG
) (
  input  logic signed [IW-1:0] x,
  output logic signed [OW-1:0] p
);

  logic signed [OW-1:0] xe;
  logic signed [OW-1:0] part [NDIG+1];

  assign xe      = {{(OW-IW){x[IW-1]}}, x};
  assign part[0] = '0;

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    localparam int D = csd_digit(CF, j);
    if (D == 0) begin : g_skip
      assign part[j+1] = part[j];
    end else begin : g_term
      fir_hp_rca #(.W(OW)) u_term (
        .a   (part[j]),
        .b   (xe <<< j),
        .sub (D < 0),
        .s   (part[j+1])
      );
    end
  end

  assign p = part[NDIG];

endmodule

// File: rtl/fir_hp_tree.sv
module fir_hp_tree
  import fir_hp_pkg::*;
#(
  parameter int W      = AW,
  parameter int N_LEAF = LEAVES,
  parameter int DEPTH  = LVL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEPTH-1:0]    lvl_en,
  input  logic signed [W-1:0] leaf [N_LEAF],
  output logic signed [W-1:0] root
);

  logic signed [W-1:0] node [DEPTH+1][N_LEAF];

  for (genvar i = 0; i < N_LEAF; i++) begin : g_in
    assign node[0][i] = leaf[i];
  end

  for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
    for (genvar i = 0; i < N_LEAF; i++) begin : g_node
      if (i < (N_LEAF >> l)) begin : g_add
        logic signed [W-1:0] sum_w;
        logic signed [W-1:0] sum_d;
        logic signed [W-1:0] sum_q;

        fir_hp_rca #(.W(W)) u_add (
          .a   (node[l-1][2*i]),
          .b   (node[l-1][2*i+1]),
          .sub (1'b0),
          .s   (sum_w)
        );

        always_comb sum_d = lvl_en[l-1] ? sum_w : sum_q;

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sum_q <= '0;
          else        sum_q <= sum_d;
        end

        assign node[l][i] = sum_q;
      end else begin : g_pad
        assign node[l][i] = '0;
      end
    end
  end

  assign root = node[DEPTH][0];

endmodule

// File: rtl/fir_hp_top.sv
module fir_hp_top
  import fir_hp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);

  localparam int PW = DW + 1;

  // valid shift chain: bit s marks a sample s+1 register stages deep
  logic [LAT:0] vld_q, vld_d;

  always_comb vld_d = {vld_q[LAT-1:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // tap delay line, advanced only by accepted samples
  sample_t tap_q [NTAP];
  sample_t tap_d [NTAP];

  always_comb begin
    for (int k = 0; k < NTAP; k++) tap_d[k] = tap_q[k];
    if (in_valid) begin
      tap_d[0] = in_sample;
      for (int k = 1; k < NTAP; k++) tap_d[k] = tap_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) tap_q[k] <= '0;
    end else begin
      tap_q <= tap_d;
    end
  end

  // stage 1: fold mirrored taps
  logic signed [PW-1:0] pre_w [NPROD];
  logic signed [PW-1:0] pre_d [NPROD];
  logic signed [PW-1:0] pre_q [NPROD];

  for (genvar k = 0; k < HALF; k++) begin : g_fold
    fir_hp_rca #(.W(PW)) u_fold (
      .a   ({tap_q[k][DW-1], tap_q[k]}),
      .b   ({tap_q[NTAP-1-k][DW-1], tap_q[NTAP-1-k]}),
      .sub (1'b0),
      .s   (pre_w[k])
    );
  end
  assign pre_w[HALF] = {tap_q[HALF][DW-1], tap_q[HALF]};

  always_comb begin
    for (int k = 0; k < NPROD; k++) pre_d[k] = vld_q[0] ? pre_w[k] : pre_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPROD; k++) pre_q[k] <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // stage 2: signed-digit shift-add products
  acc_t prod_w [NPROD];
  acc_t prod_d [NPROD];
  acc_t prod_q [NPROD];

  for (genvar k = 0; k < NPROD; k++) begin : g_prod
    fir_hp_csd_mult #(
      .IW   (PW),
      .OW   (AW),
      .CF   (COEF[k]),
      .NDIG (CDIG)
    ) u_mult (
      .x (pre_q[k]),
      .p (prod_w[k])
    );
  end

  always_comb begin
    for (int k = 0; k < NPROD; k++) prod_d[k] = vld_q[1] ? prod_w[k] : prod_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPROD; k++) prod_q[k] <= '0;
    end else begin
      prod_q <= prod_d;
    end
  end

  // stages 3..: balanced registered adder tree
  acc_t leaf [LEAVES];
  acc_t root_sum;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NPROD) begin : g_used
      assign leaf[i] = prod_q[i];
    end else begin : g_zero
      assign leaf[i] = '0;
    end
  end

  fir_hp_tree #(
    .W      (AW),
    .N_LEAF (LEAVES),
    .DEPTH  (LVL)
  ) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_en (vld_q[LVL+1:2]),
    .leaf   (leaf),
    .root   (root_sum)
  );

  // final stage: scale down and saturate
  acc_t                scaled;
  logic                ovf;
  logic [DW-1:0]       res;
  logic [DW-1:0]       out_d, out_q;

  assign scaled = root_sum >>> FRAC;
  assign ovf    = ~((&scaled[AW-1:DW-1]) | ~(|scaled[AW-1:DW-1]));

  always_comb begin
    if (ovf) res = scaled[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else     res = scaled[DW-1:0];
    out_d = vld_q[LAT-1] ? res : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out_sample = out_q;
  assign out_valid  = vld_q[LAT];

endmodule

// File: rtl/fir_hp_checker.sv
module fir_hp_checker
  import fir_hp_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_sample,
  input acc_t          root
);

  localparam acc_t HI = acc_t'((1 << (DW - 1)) - 1);
  localparam acc_t LO = acc_t'(-(1 << (DW - 1)));

  logic [LAT:0] vh_q;
  logic [LAT:0] up_q;
  acc_t         root_sc;

  assign root_sc = root >>> FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vh_q <= '0;
      up_q <= '0;
    end else begin
      vh_q <= {vh_q[LAT-1:0], in_valid};
      up_q <= {up_q[LAT-1:0], 1'b1};
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    up_q[LAT] |-> (out_valid == vh_q[LAT]));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));

  assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q[0] && out_valid && ($past(root_sc) > HI)) |-> (out_sample == HI[DW-1:0]));

  assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q[0] && out_valid && ($past(root_sc) < LO)) |-> (out_sample == LO[DW-1:0]));

  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q[0] && out_valid && ($past(root_sc) <= HI) && ($past(root_sc) >= LO))
      |-> (out_sample == $past(root_sc[DW-1:0])));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R6: assert (!out_valid && (out_sample == '0));
    end
  end

endmodule

bind fir_hp_top fir_hp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .root       (root_sum)
);

// File: tb/fir_hp_top_tb.sv
module fir_hp_top_tb;

  localparam int L  = 5;
  localparam int NT = 7;
  localparam int MAXP = 8388607;
  localparam int MINN = -8388608;

  int h [NT] = '{-8, -20, -36, 128, -36, -20, -8};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_sample;
  logic        out_valid;
  logic [23:0] out_sample;

  always #5 clk = ~clk;

  fir_hp_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    run_chk = 1'b0;
  int    hist [NT];
  bit    vq [$];
  int    eq [$];
  int    last_out = 0;
  int    qn, got, want;
  bit    ev;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_out();
    longint s;
    s = 0;
    for (int k = 0; k < NT; k++) s = s + longint'(h[k]) * longint'(hist[k]);
    s = s >>> 7;
    if (s > MAXP) s = MAXP;
    if (s < MINN) s = MINN;
    return int'(s);
  endfunction

  // reference model: advances on every accepted sample
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) hist[k] = 0;
      vq.delete();
      eq.delete();
      last_out = 0;
    end else begin
      vq.push_back(in_valid);
      if (in_valid) begin
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(in_sample));
        eq.push_back(ref_out());
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      qn  = vq.size();
      ev  = (qn > L) ? vq[qn-1-L] : 1'b0;
      got = int'($signed(out_sample));
      chk(out_valid == ev, "R2", int'(out_valid), int'(ev));
      if (out_valid && ev) begin
        want = (eq.size() > 0) ? eq.pop_front() : 0;
        chk(got == want, tag, got, want);
        last_out = got;
      end else if (!out_valid) begin
        chk(got == last_out, "R8", got, last_out);
      end
    end
  end

  task automatic send(int v);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 24'(v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 24'h5A5A5A;  // must be ignored (R3)
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    chk(out_sample == 24'd0, "R6", int'($signed(out_sample)), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    chk(out_sample == 24'd0, "R6", int'($signed(out_sample)), 0);
    rst_n   = 1'b1;
    run_chk = 1'b1;

    // impulse
    tag = "R7";
    send(65536);
    for (int i = 0; i < 8; i++) send(0);
    idle(8);

    // constant input
    tag = "R5";
    for (int i = 0; i < 14; i++) send(1000000);
    idle(3);
    for (int i = 0; i < 10; i++) send(-777777);
    idle(8);

    // bubbles with garbage on the data lines
    tag = "R3";
    for (int i = 0; i < 12; i++) begin
      send(i * 40000 - 200000);
      idle(1 + (i % 3));
    end
    idle(8);

    // saturation both ways
    tag = "R4";
    for (int i = 0; i < 3; i++) send(-MAXP);
    send(MAXP);
    for (int i = 0; i < 3; i++) send(-MAXP);
    for (int i = 0; i < 3; i++) send(MAXP);
    send(MINN);
    for (int i = 0; i < 3; i++) send(MAXP);
    idle(8);

    // alternating full scale
    tag = "R1";
    for (int i = 0; i < 20; i++) send((i % 2 == 0) ? MAXP : MINN);
    idle(8);

    // random samples with random bubbles
    for (int i = 0; i < 300; i++) begin
      send(int'($urandom) >>> 8);
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(8);

    // reset with samples in flight, then an impulse on cleared history
    tag = "R6";
    send(3000000);
    send(-2500000);
    send(1234567);
    do_reset();
    send(131072);
    for (int i = 0; i < 7; i++) send(0);
    idle(10);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule